// File: doc/BRIEF.md
# Accumulator Hazard Stall Detector

This block guards the operand stage of a pipelined core whose multiply-accumulate unit has several accumulators. Each cycle the issuing slot offers one decoded instruction: a valid bit, a 2-bit class, a source accumulator index and a destination accumulator index. The block keeps two pipeline slots. One is the operand stage, which holds the instruction that has just entered. The other is the execute slot, which holds the instruction one position ahead and drives the outputs. When an instruction is accepted, the block compares it with the instruction it replaces in the operand stage.

Only one pairing stalls the pipe. A store-accumulator instruction stalls when it reads exactly the accumulator that a valid MAC or load-accumulator instruction just ahead of it writes. No other combination stalls. A store of another accumulator, a load after a MAC, or any pair separated by a bubble goes through at full rate. During a stall the younger instruction waits in the operand stage and the older one moves on, with bubbles behind it. The issuing slot is told to hold its instruction. Stalling delays instructions but never drops, repeats or reorders them.

Top module: `acc_hazard_stall`

## Requirements
- R1: Class codes are 2'b00 other, 2'b01 MAC, 2'b10 load-accumulator and 2'b11 store-accumulator. MAC and load write the accumulator named by the destination field, and a store reads the one named by the source field. A valid store accepted directly after a valid MAC or load whose destination equals the store's source raises `stall`.
- R2: A stall keeps `stall` high for exactly STALL_CYCLES (default 2) consecutive cycles. It starts in the cycle after the store is accepted.
- R3: A valid store that follows a valid MAC or load writing a different accumulator causes no stall.
- R4: MAC to accumulator 0, MAC to accumulator 0, then a store of accumulator 1, offered back to back, produce zero stall cycles.
- R5: No pairing other than the R1 case stalls. This covers a load after a MAC, two producers in a row, and any pair in which either instruction has the other class or is invalid.
- R6: A bubble (an accepted slot with the valid bit low) between a producer and a store of the same accumulator removes the stall.
- R7: While `stall` is high, `iss_hold` is high and the issuing slot is not accepted. The store stays in the operand stage. The older instruction appears on the execute outputs in the cycle after the store is accepted, and the execute outputs then carry bubbles for STALL_CYCLES cycles before the store appears.
- R8: Every valid accepted instruction appears exactly once on the execute outputs, in issue order, with its class and indices unchanged, whether or not stalls occur.
- R9: During reset and after it, `stall`, `iss_hold` and `exe_valid` are low. A store issued first after reset does not stall, because no producer has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issuing slot holds an instruction |
| iss_cls | input | 2 | Instruction class code |
| iss_src | input | IDX_W | Accumulator read by a store |
| iss_dst | input | IDX_W | Accumulator written by a MAC or load |
| iss_hold | output | 1 | Issuing slot must keep its instruction |
| stall | output | 1 | Operand stage is stalled |
| exe_valid | output | 1 | Execute slot holds an instruction |
| exe_cls | output | 2 | Class of the execute-slot instruction |
| exe_src | output | IDX_W | Source index of the execute-slot instruction |
| exe_dst | output | IDX_W | Destination index of the execute-slot instruction |

## Verification
The assertions assume that the issue inputs are known at every clock edge and that reset is applied for at least one edge before checking starts. They do not assume the issuer obeys `iss_hold`, because the block ignores the offered instruction while it holds. The bench keeps within these limits by changing inputs only at the falling edge and by keeping each instruction on the inputs until an edge where `iss_hold` was low. It then sweeps every class, index and valid-bit combination for a producer followed by a consumer, with bubbles between pairs so that each pair starts from a clean stage.

// File: rtl/acc_hz_pkg.sv
package acc_hz_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_MAC   = 2'b01,
    CLS_LDACC = 2'b10,
    CLS_STACC = 2'b11
  } acc_cls_e;

  function automatic logic writes_acc(input acc_cls_e c);
    return (c == CLS_MAC) || (c == CLS_LDACC);
  endfunction

  function automatic logic reads_acc(input acc_cls_e c);
    return (c == CLS_STACC);
  endfunction

endpackage

// File: rtl/acc_hz_match.sv
module acc_hz_match
  import acc_hz_pkg::*;
#(
  parameter int unsigned NUM_ACC = 4,
  localparam int unsigned IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             prod_valid,
  input  acc_cls_e         prod_cls,
  input  logic [IDX_W-1:0] prod_dst,
  input  logic             cons_valid,
  input  acc_cls_e         cons_cls,
  input  logic [IDX_W-1:0] cons_src,
  output logic             hazard
);

  logic               prod_wr;
  logic               cons_rd;
  logic [NUM_ACC-1:0] wr_hot;
  logic [NUM_ACC-1:0] rd_hot;

  assign prod_wr = prod_valid && writes_acc(prod_cls);
  assign cons_rd = cons_valid && reads_acc(cons_cls);

  // One-hot decode per accumulator; a hazard is an overlap of writer and reader
  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    assign wr_hot[i] = prod_wr && (prod_dst == IDX_W'(i));
    assign rd_hot[i] = cons_rd && (cons_src == IDX_W'(i));
  end

  assign hazard = |(wr_hot & rd_hot);

endmodule

// File: rtl/acc_hz_timer.sv
module acc_hz_timer #(
  parameter int unsigned STALL_CYCLES = 2,
  localparam int unsigned RW = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1,
  localparam int unsigned LW = $clog2(STALL_CYCLES + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic          busy_q;
  logic [RW-1:0] remain_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      remain_q <= RW'(STALL_CYCLES - 1);
    end else if (busy_q) begin
      if (remain_q == '0) busy_q <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  // Run-length counter used only to check the stall window width
  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (busy_q) len_q <= len_q + 1'b1;
    else             len_q <= '0;
  end

  assign busy = busy_q;

  // R2: a stall window never exceeds the configured length
  a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (len_q < LW'(STALL_CYCLES)));

  // R2: a stall window that ends has lasted exactly the configured length
  a_r2_window_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (len_q == LW'(STALL_CYCLES)));

endmodule

// File: rtl/acc_hz_slot.sv
module acc_hz_slot
  import acc_hz_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic             d_valid,
  input  acc_cls_e         d_cls,
  input  logic [IDX_W-1:0] d_src,
  input  logic [IDX_W-1:0] d_dst,
  output logic             q_valid,
  output acc_cls_e         q_cls,
  output logic [IDX_W-1:0] q_src,
  output logic [IDX_W-1:0] q_dst
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_cls   <= CLS_OTHER;
      q_src   <= '0;
      q_dst   <= '0;
    end else if (load) begin
      q_valid <= d_valid;
      q_cls   <= d_cls;
      q_src   <= d_src;
      q_dst   <= d_dst;
    end else if (clear) begin
      q_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/acc_hazard_stall.sv
module acc_hazard_stall
  import acc_hz_pkg::*;
#(
  parameter int unsigned NUM_ACC      = 4,
  parameter int unsigned STALL_CYCLES = 2,
  localparam int unsigned IDX_W       = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [1:0]       iss_cls,
  input  logic [IDX_W-1:0] iss_src,
  input  logic [IDX_W-1:0] iss_dst,
  output logic             iss_hold,
  output logic             stall,
  output logic             exe_valid,
  output logic [1:0]       exe_cls,
  output logic [IDX_W-1:0] exe_src,
  output logic [IDX_W-1:0] exe_dst
);

  acc_cls_e         iss_cls_e;
  logic             stall_w;
  logic             accept;
  logic             hazard;

  logic             stg_valid;
  acc_cls_e         stg_cls;
  logic [IDX_W-1:0] stg_src;
  logic [IDX_W-1:0] stg_dst;
  acc_cls_e         exe_cls_e;

  assign iss_cls_e = acc_cls_e'(iss_cls);
  assign accept    = !stall_w;

  // Operand stage: takes the offered instruction unless stalled
  acc_hz_slot #(.IDX_W(IDX_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .clear   (1'b0),
    .d_valid (iss_valid),
    .d_cls   (iss_cls_e),
    .d_src   (iss_src),
    .d_dst   (iss_dst),
    .q_valid (stg_valid),
    .q_cls   (stg_cls),
    .q_src   (stg_src),
    .q_dst   (stg_dst)
  );

  // Execute slot: receives the older instruction, or a bubble while stalled
  acc_hz_slot #(.IDX_W(IDX_W)) u_exec (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .clear   (stall_w),
    .d_valid (stg_valid),
    .d_cls   (stg_cls),
    .d_src   (stg_src),
    .d_dst   (stg_dst),
    .q_valid (exe_valid),
    .q_cls   (exe_cls_e),
    .q_src   (exe_src),
    .q_dst   (exe_dst)
  );

  // Producer is the instruction being displaced from the operand stage
  acc_hz_match #(.NUM_ACC(NUM_ACC)) u_match (
    .prod_valid (stg_valid),
    .prod_cls   (stg_cls),
    .prod_dst   (stg_dst),
    .cons_valid (iss_valid),
    .cons_cls   (iss_cls_e),
    .cons_src   (iss_src),
    .hazard     (hazard)
  );

  acc_hz_timer #(.STALL_CYCLES(STALL_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (accept && hazard),
    .busy  (stall_w)
  );

  assign stall    = stall_w;
  assign iss_hold = stall_w;
  assign exe_cls  = exe_cls_e;

  // R1: a stall only begins after a matching producer/store pair was accepted
  a_r1_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_w) |-> $past(iss_valid && (iss_cls == 2'b11) && stg_valid &&
                             ((stg_cls == CLS_MAC) || (stg_cls == CLS_LDACC)) &&
                             (stg_dst == iss_src)));

  // R7: the younger instruction does not move while stalled
  a_r7_stage_held: assert property (@(posedge clk) disable iff (rst)
    stall_w |=> ($stable(stg_valid) && $stable(stg_cls) &&
                 $stable(stg_src) && $stable(stg_dst)));

  // R7: the execute slot receives bubbles while stalled
  a_r7_exec_bubble: assert property (@(posedge clk) disable iff (rst)
    stall_w |=> !exe_valid);

endmodule

// File: tb/acc_hazard_stall_test.sv
module acc_hazard_stall_test;

  localparam logic [1:0] C_OTH = 2'b00;
  localparam logic [1:0] C_MAC = 2'b01;
  localparam logic [1:0] C_LD  = 2'b10;
  localparam logic [1:0] C_ST  = 2'b11;

  logic       clk = 1'b0;
  logic       rst;
  logic       iss_valid;
  logic [1:0] iss_cls, iss_src, iss_dst;
  logic       iss_hold, stall, exe_valid;
  logic [1:0] exe_cls, exe_src, exe_dst;

  int checks = 0;
  int fails  = 0;
  int stall_seen = 0;
  int wr_p = 0;
  int rd_p = 0;
  bit mon_en = 1'b0;
  logic [5:0] exp_q [256];

  always #10 clk = ~clk;

  acc_hazard_stall uut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_src(iss_src), .iss_dst(iss_dst),
    .iss_hold(iss_hold), .stall(stall),
    .exe_valid(exe_valid), .exe_cls(exe_cls), .exe_src(exe_src), .exe_dst(exe_dst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one instruction and wait until an edge accepts it
  task automatic send(input bit v, input logic [1:0] c, input logic [1:0] s,
                      input logic [1:0] d);
    bit took;
    iss_valid = v; iss_cls = c; iss_src = s; iss_dst = d;
    do begin
      took = !iss_hold;
      @(posedge clk);
      @(negedge clk);
    end while (!took);
    if (v) begin
      exp_q[wr_p % 256] = {c, s, d};
      wr_p++;
    end
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) send(1'b0, C_OTH, 2'd0, 2'd0);
  endtask

  // Count stall cycles and check the execute stream order (R8)
  always @(negedge clk) begin
    if (mon_en) begin
      if (stall) stall_seen++;
      if (exe_valid) begin
        chk({exe_cls, exe_src, exe_dst} == exp_q[rd_p % 256], "R8 order",
            int'({exe_cls, exe_src, exe_dst}), int'(exp_q[rd_p % 256]));
        rd_p++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; iss_valid = 1'b0; iss_cls = C_OTH; iss_src = 2'd0; iss_dst = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stall == 1'b0,     "R9 reset stall", int'(stall), 0);
    chk(iss_hold == 1'b0,  "R9 reset hold", int'(iss_hold), 0);
    chk(exe_valid == 1'b0, "R9 reset exe_valid", int'(exe_valid), 0);
    rst = 1'b0;
    mon_en = 1'b1;

    // R9: first store after reset has no producer ahead of it
    stall_seen = 0;
    send(1'b1, C_ST, 2'd0, 2'd0);
    flush();
    chk(stall_seen == 0, "R9 first store", stall_seen, 0);

    // R2 / R7: exact cycle-by-cycle stall window
    send(1'b1, C_MAC, 2'd3, 2'd2);
    send(1'b1, C_ST, 2'd2, 2'd0);
    iss_valid = 1'b0;
    chk(stall == 1'b1,     "R2 stall cycle 1", int'(stall), 1);
    chk(iss_hold == 1'b1,  "R7 hold cycle 1", int'(iss_hold), 1);
    chk(exe_valid && exe_cls == C_MAC, "R7 older advances", int'(exe_cls), int'(C_MAC));
    @(negedge clk);
    chk(stall == 1'b1,     "R2 stall cycle 2", int'(stall), 1);
    chk(exe_valid == 1'b0, "R7 bubble 1", int'(exe_valid), 0);
    @(negedge clk);
    chk(stall == 1'b0,     "R2 stall ends", int'(stall), 0);
    chk(iss_hold == 1'b0,  "R7 hold ends", int'(iss_hold), 0);
    chk(exe_valid == 1'b0, "R7 bubble 2", int'(exe_valid), 0);
    @(negedge clk);
    chk(exe_valid && exe_cls == C_ST, "R7 store emerges", int'(exe_cls), int'(C_ST));
    flush();

    // R4: two MACs to acc0 then a store of acc1
    stall_seen = 0;
    send(1'b1, C_MAC, 2'd1, 2'd0);
    send(1'b1, C_MAC, 2'd2, 2'd0);
    send(1'b1, C_ST,  2'd1, 2'd0);
    flush();
    chk(stall_seen == 0, "R4 mac mac store", stall_seen, 0);

    // R6: bubble between producer and matching store
    stall_seen = 0;
    send(1'b1, C_LD, 2'd0, 2'd1);
    send(1'b0, C_OTH, 2'd0, 2'd0);
    send(1'b1, C_ST, 2'd1, 2'd0);
    flush();
    chk(stall_seen == 0, "R6 bubble clears", stall_seen, 0);

    // R1 / R3 / R5: exhaustive producer-consumer sweep
    for (int pv = 0; pv < 2; pv++)
      for (int pc = 0; pc < 4; pc++)
        for (int pd = 0; pd < 4; pd++)
          for (int cv = 0; cv < 2; cv++)
            for (int cc = 0; cc < 4; cc++)
              for (int cs = 0; cs < 4; cs++)
                for (int cd = 0; cd < 4; cd++) begin
                  bit prod, cons;
                  int exp_stall;
                  string tag;
                  prod = (pv == 1) && (pc == 1 || pc == 2);
                  cons = (cv == 1) && (cc == 3);
                  exp_stall = (prod && cons && cs == pd) ? 2 : 0;
                  if (exp_stall != 0)      tag = "R1 hazard";
                  else if (prod && cons)   tag = "R3 other acc";
                  else                     tag = "R5 no hazard";
                  send(1'b0, C_OTH, 2'd0, 2'd0);
                  stall_seen = 0;
                  send(pv[0], pc[1:0], 2'(cd), pd[1:0]);
                  send(cv[0], cc[1:0], cs[1:0], cd[1:0]);
                  flush();
                  chk(stall_seen == exp_stall, tag, stall_seen, exp_stall);
                end

    flush();
    chk(rd_p == wr_p, "R8 none lost", rd_p, wr_p);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule